// File: doc/BRIEF.md
# Stochastic Integration Result Accumulator

This block is the control and de-randomizing stage of a stochastic numerical integrator. A start request launches one run of exactly L·M clock cycles. L = 2^LOG_L is the number of bits that encode each evaluation point, and M = 2^LOG_M is the number of points swept across the unit interval. During the run the block holds a sweep-enable output high for the external sweep unit. It then opens its own counting window PIPE_LAT cycles later, so that the window lines up with the register stages in the sweep and evaluation path.

Inside that window the block counts every evaluator output bit that is 1 and flagged valid. Because L·M is a power of two, no divider is needed. The final count, read as an unsigned fraction with all LOG_L+LOG_M bits after the binary point, is directly the average of all function evaluations, which is the integral estimate. A single-cycle done pulse marks the end of a run. The result then holds until the next accepted start. A count that reaches L·M, which would be 1.0, is reported as the largest representable fraction.

Top module: `sint_accum`

## Requirements
- R1: While reset is asserted and after it is released, sweep_en_o, busy_o and done_o are 0 and result_o is 0.
- R2: A start_i sampled high while busy_o is low is accepted. sweep_en_o is then high for exactly L·M consecutive cycles, beginning in the cycle after the accepting edge.
- R3: Counting edges are edge numbers PIPE_LAT+1 through PIPE_LAT+L·M, where the accepting edge is edge 0. An input bit presented at any other edge is not counted, whatever its value or valid flag.
- R4: Within the window, the count rises by one at a counting edge if and only if sbit_i is 1 and sbit_vld_i is 1 at that edge.
- R5: After a run, result_o equals the number of counted ones. The value is read as an unsigned fraction, count / 2^(LOG_L+LOG_M).
- R6: When the count equals L·M, result_o is all ones (saturated full scale) and does not wrap to 0.
- R7: done_o is high for exactly one cycle, the cycle after edge PIPE_LAT+L·M. busy_o is high from the cycle after edge 0 until that same edge, and falls as done_o rises.
- R8: An accepted start clears result_o to 0 in the following cycle. Once done_o has pulsed, result_o stays unchanged until the next accepted start.
- R9: A start_i sampled high while busy_o is high is ignored: the run length, the window, the done timing and the count are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request to begin a run |
| sbit_i | input | 1 | Stochastic output bit of the evaluator |
| sbit_vld_i | input | 1 | Qualifies sbit_i |
| sweep_en_o | output | 1 | High for the L·M cycles in which the sweep unit advances |
| busy_o | output | 1 | Run in progress, including pipeline drain |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| result_o | output | LOG_L+LOG_M | Integral estimate as an unsigned binary fraction |

## Verification
The bench builds the block with LOG_L=2, LOG_M=3 and PIPE_LAT=2, which gives a 32-cycle run and a 5-bit result. That size makes it cheap to sweep every possible number of ones from 0 to 32, so both exact counts and the single saturating case are covered. Bits of 1 are driven before and after the window on every run, which exposes any off-by-one in the window alignment. Further runs add gapped valid flags, a modular bit pattern and a start issued mid-run.

// File: rtl/sint_pkg.sv
package sint_pkg;
  // Bits needed to hold a count of ones from 0 up to and including 2^w.
  function automatic int cnt_width(input int w);
    return w + 1;
  endfunction
endpackage

// File: rtl/sint_sweep_seq.sv
module sint_sweep_seq #(
  parameter int RUN_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_acc_i,
  output logic issue_o
);
  localparam logic [RUN_W-1:0] LAST_IDX = '1;

  logic             issue_q, issue_d;
  logic [RUN_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    issue_d = issue_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    if (start_acc_i) begin
      issue_d = 1'b1;
      idx_d   = '0;
      idx_en  = 1'b1;
    end else if (issue_q) begin
      idx_en = 1'b1;
      idx_d  = idx_q + 1'b1;
      if (idx_q == LAST_IDX) issue_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      issue_q <= issue_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign issue_o = issue_q;

  // R2: the sweep ends only after the last index has been issued
  assert_run_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(issue_q) |-> $past(idx_q) == LAST_IDX);
endmodule

// File: rtl/sint_win_align.sv
module sint_win_align #(
  parameter int PIPE_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  output logic win_o,
  output logic last_o,
  output logic drain_o
);
  logic [PIPE_LAT-1:0] stage_q, stage_d;
  logic [PIPE_LAT:0]   chain;

  assign chain   = {stage_q, issue_i};
  assign stage_d = chain[PIPE_LAT-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign win_o   = chain[PIPE_LAT];
  assign last_o  = chain[PIPE_LAT] & ~chain[PIPE_LAT-1];
  assign drain_o = |stage_q;

  // R3: the window opens only after the sweep has been running
  assert_win_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_o) |-> $past(stage_q[0]));
endmodule

// File: rtl/sint_ones_ctr.sv
module sint_ones_ctr
  import sint_pkg::*;
#(
  parameter int RES_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             win_i,
  input  logic             last_i,
  input  logic             sbit_i,
  input  logic             vld_i,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int CW = cnt_width(RES_W);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en, inc;
  logic          done_q, done_d;

  assign inc = win_i & vld_i & sbit_i;

  always_comb begin
    cnt_en = clr_i | inc;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
    done_d = last_i & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      done_q <= done_d;
    end
  end

  generate
    if (RES_W > 0) begin : g_sat
      assign result_o = cnt_q[CW-1] ? {RES_W{1'b1}} : cnt_q[RES_W-1:0];
    end
  endgenerate
  assign done_o = done_q;

  // R6: the count never exceeds L*M
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[CW-1] |-> cnt_q[CW-2:0] == '0);
  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: without a clear or a counted one the result holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc) |=> $stable(result_o));
endmodule

// File: rtl/sint_accum.sv
module sint_accum #(
  parameter int LOG_L    = 2,
  parameter int LOG_M    = 3,
  parameter int PIPE_LAT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   sbit_i,
  input  logic                   sbit_vld_i,
  output logic                   sweep_en_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [LOG_L+LOG_M-1:0] result_o
);
  localparam int RES_W = LOG_L + LOG_M;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       issue, win, last, drain, start_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign busy_o     = issue | drain;
  assign start_acc  = start_i & ~busy_o;
  assign sweep_en_o = issue;

  sint_sweep_seq #(.RUN_W(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start_acc_i(start_acc), .issue_o(issue));

  sint_win_align #(.PIPE_LAT(PIPE_LAT)) u_win (
    .clk(clk), .rst_n(rst_int_n), .issue_i(issue),
    .win_o(win), .last_o(last), .drain_o(drain));

  sint_ones_ctr #(.RES_W(RES_W)) u_ctr (
    .clk(clk), .rst_n(rst_int_n), .clr_i(start_acc), .win_i(win),
    .last_i(last), .sbit_i(sbit_i), .vld_i(sbit_vld_i),
    .done_o(done_o), .result_o(result_o));

  // R9: a sweep only begins from an idle start
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sweep_en_o) |-> $past(start_i && !busy_o));
  // R7: done arrives as busy falls
  assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> !busy_o);
endmodule

// File: tb/sint_accum_bench.sv
module sint_accum_bench;
  localparam int LL = 2, LM = 3, PL = 2;
  localparam int W = LL + LM;
  localparam int N = 1 << W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, sbit_i = 1'b0, sbit_vld_i = 1'b0;
  logic sweep_en_o, busy_o, done_o;
  logic [W-1:0] result_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sint_accum #(.LOG_L(LL), .LOG_M(LM), .PIPE_LAT(PL)) u_sint_accum (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sbit_i(sbit_i),
    .sbit_vld_i(sbit_vld_i), .sweep_en_o(sweep_en_o), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: ones for the first j window edges; 1: every third edge;
  // 2: all ones with gapped valid; 3: mode 1 plus a start mid-run
  task automatic run(input int mode, input int j);
    int exp = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 clear on start", int'(result_o), 0);
    for (int k = 1; k <= N + PL + 3; k++) begin
      int  w = k - PL;
      bit  inwin = (w >= 1) && (w <= N);
      bit  b, v;
      v = 1'b1;
      if (!inwin) b = 1'b1;
      else if (mode == 0) b = (w <= j);
      else if (mode == 2) begin b = 1'b1; v = (w % 4 != 0); end
      else b = (w % 3 == 0);
      sbit_i = b; sbit_vld_i = v;
      start_i = (mode == 3) && (k == 4);
      if (inwin && b && v) exp++;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk("R2 sweep_en", int'(sweep_en_o), int'(k <= N - 1));
      chk("R7 busy", int'(busy_o), int'(k < N + PL));
      chk("R7 done", int'(done_o), int'(k == N + PL));
    end
    if (exp >= N) exp = N - 1; // R6 saturation
    chk("R5 R3 R4 R6 R9 result", int'(result_o), exp);
    for (int h = 0; h < 3; h++) begin
      sbit_i = 1'b1; sbit_vld_i = 1'b1;
      @(negedge clk);
      chk("R8 hold", int'(result_o), exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sweep_en", int'(sweep_en_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 result", int'(result_o), 0);
    for (int j = 0; j <= N; j++) run(0, j);
    run(1, 0);
    run(2, 0);
    run(3, 0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule